// File: doc/BRIEF.md
# Slave Sensor Sync Pulse Generator

This block produces the vertical and horizontal synchronisation pulse trains that pace an image sensor running as a timing slave. Every length is a count of cycles of the clock the block runs on, which is the sensor input clock. A frame counter sets the vertical period and the vertical pulse width. A line counter, held by a two-state controller, starts a programmable number of cycles after each frame start and then repeats horizontal pulses at the line period until the frame ends. The line counter restarts at every frame start, so the horizontal train stays phase-locked to the vertical one.

Software programs the block through a simple write port. There are four complete timing sets. Each set holds a vertical period, a horizontal period, two pulse widths, a horizontal start delay and a packed pin word with a polarity bit and an enable bit per output. A set selector chooses which set later writes land in. The same selector also chooses which set the generator runs from, starting at the next frame start. Period, width, delay and set changes are copied into shadow registers only at a frame start, so a running frame never shows a clipped pulse. Polarity and enable act on the pin straight away.

The horizontal controller has two states. `HS_WAIT` counts the start delay with the output idle. `HS_RUN` produces line after line. A frame start enters `HS_WAIT` when the new delay is non-zero and `HS_RUN` when it is zero. `HS_WAIT` moves to `HS_RUN` when the delay expires. `HS_RUN` stays in `HS_RUN` and wraps its counter at each line end. Reset enters `HS_RUN` with all widths zero.

Top module: `slave_sync_gen`

## Requirements
- R1: A frame lasts exactly the programmed vertical period in cycles, and the vsync active phase begins once per frame. A period of 0 counts as 1.
- R2: vsync is active during the first N cycles of each frame, where N is the vertical width. A width of 0 gives no pulse. A width at or above the period keeps vsync active without a break.
- R3: The first hsync active cycle falls the programmed delay number of cycles after the vsync active phase starts. After that, hsync pulses start every horizontal period until the frame ends, and the next frame restarts the sequence.
- R4: Each hsync pulse lasts the horizontal width. A width of 0 suppresses every hsync pulse. A width at or above the horizontal period keeps hsync active from the end of the delay to the end of the frame.
- R5: In the pin word, bit 16 inverts hsync and bit 17 inverts vsync (0 = active high, 1 = active low). A new polarity shows on the pin two sample points after the write is presented, without waiting for a frame start.
- R6: In the pin word, bit 30 enables hsync and bit 31 enables vsync. A disabled output is held at its idle level, which equals its invert bit.
- R7: A period, width or delay written during a frame leaves that frame unchanged and applies from the next frame start.
- R8: The selector (address 6, value 0 to 3) routes writes to addresses 0 to 5 into that set. The generator switches to the selected set at the next frame start. The other sets keep their values.
- R9: After reset every register is zero and both outputs are low.
- R10: The address map is 0 = pin word, 1 = vertical period, 2 = horizontal period, 3 = vertical width, 4 = horizontal width, 5 = horizontal delay, 6 = selector. Timing values use data bits 15:0. Pin word bits 15:0 and 29:18 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sensor input clock; all counts are in these cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| vsync_o | output | 1 | Vertical sync pulse to the sensor |
| hsync_o | output | 1 | Horizontal sync pulse to the sensor |

## Verification
A write is captured at the first rising edge after it is presented, and the output register adds one more edge. A polarity or enable change therefore appears at the second falling-edge sample after the write, and the bench checks it at exactly that sample. Timing changes only appear after a frame start, so the bench first lines up on a vsync active edge and then measures widths, periods and the hsync delay as sample counts from that edge, which cancels the fixed pipeline offset. Before measuring, each scenario lets one whole frame pass after its last write, because a frame start may fall in the middle of a write sequence.

// File: rtl/sns_sync_pkg.sv
package sns_sync_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PIN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_VPER = 3'd1;
    localparam logic [ADDR_W-1:0] A_HPER = 3'd2;
    localparam logic [ADDR_W-1:0] A_VWID = 3'd3;
    localparam logic [ADDR_W-1:0] A_HWID = 3'd4;
    localparam logic [ADDR_W-1:0] A_HDLY = 3'd5;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd6;

    // pin word bit positions
    localparam int unsigned B_HINV = 16;
    localparam int unsigned B_VINV = 17;
    localparam int unsigned B_HEN  = 30;
    localparam int unsigned B_VEN  = 31;

    typedef struct packed {
        logic v_en;
        logic h_en;
        logic v_inv;
        logic h_inv;
    } pin_cfg_t;

    typedef enum logic [0:0] {
        HS_WAIT = 1'b0,
        HS_RUN  = 1'b1
    } hs_state_e;

endpackage

// File: rtl/sns_sync_regs.sv
module sns_sync_regs
    import sns_sync_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_SET = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  run_idx,
    output pin_cfg_t          run_cfg,
    output logic [IDX_W-1:0]  sel_o,
    output logic [CNT_W-1:0]  nx_vper,
    output logic [CNT_W-1:0]  nx_hper,
    output logic [CNT_W-1:0]  nx_vwid,
    output logic [CNT_W-1:0]  nx_hwid,
    output logic [CNT_W-1:0]  nx_hdly
);

    pin_cfg_t         cfg_arr  [N_SET];
    logic [CNT_W-1:0] vper_arr [N_SET];
    logic [CNT_W-1:0] hper_arr [N_SET];
    logic [CNT_W-1:0] vwid_arr [N_SET];
    logic [CNT_W-1:0] hwid_arr [N_SET];
    logic [CNT_W-1:0] hdly_arr [N_SET];

    logic [IDX_W-1:0] sel_q;
    logic [CNT_W-1:0] fld;
    pin_cfg_t         cfg_wd;
    logic             unused_wr;

    assign fld       = wr_data[CNT_W-1:0];
    assign unused_wr = ^wr_data;

    // only the four defined pin bits are stored; reserved bits are dropped here
    always_comb begin
        cfg_wd.v_en  = wr_data[B_VEN];
        cfg_wd.h_en  = wr_data[B_HEN];
        cfg_wd.v_inv = wr_data[B_VINV];
        cfg_wd.h_inv = wr_data[B_HINV];
    end

    // set selector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && (wr_addr == A_SEL)) begin
            sel_q <= wr_data[IDX_W-1:0];
        end
    end

    // one storage slice per timing set
    for (genvar g = 0; g < N_SET; g++) begin : g_set
        pin_cfg_t         cfg_r;
        logic [CNT_W-1:0] vper_r, hper_r, vwid_r, hwid_r, hdly_r;
        logic             hit;

        assign hit = wr_en && (sel_q == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r  <= '0;
                vper_r <= '0;
                hper_r <= '0;
                vwid_r <= '0;
                hwid_r <= '0;
                hdly_r <= '0;
            end else if (hit) begin
                unique case (wr_addr)
                    A_PIN:   cfg_r  <= cfg_wd;
                    A_VPER:  vper_r <= fld;
                    A_HPER:  hper_r <= fld;
                    A_VWID:  vwid_r <= fld;
                    A_HWID:  hwid_r <= fld;
                    A_HDLY:  hdly_r <= fld;
                    default: ;
                endcase
            end
        end

        assign cfg_arr[g]  = cfg_r;
        assign vper_arr[g] = vper_r;
        assign hper_arr[g] = hper_r;
        assign vwid_arr[g] = vwid_r;
        assign hwid_arr[g] = hwid_r;
        assign hdly_arr[g] = hdly_r;
    end

    // pin controls follow the running set; timing feeds the next frame from the selected set
    assign run_cfg = cfg_arr[run_idx];
    assign sel_o   = sel_q;
    assign nx_vper = vper_arr[sel_q];
    assign nx_hper = hper_arr[sel_q];
    assign nx_vwid = vwid_arr[sel_q];
    assign nx_hwid = hwid_arr[sel_q];
    assign nx_hdly = hdly_arr[sel_q];

    // R8: the selector moves only through its own address
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == A_SEL)) |=> $stable(sel_q));

endmodule

// File: rtl/sns_sync_vtimer.sv
module sns_sync_vtimer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] nx_vper,
    input  logic [CNT_W-1:0] nx_vwid,
    input  logic [CNT_W-1:0] nx_hper,
    input  logic [CNT_W-1:0] nx_hwid,
    input  logic [CNT_W-1:0] nx_hdly,
    input  logic [IDX_W-1:0] nx_idx,
    output logic             frame_start,
    output logic             vact,
    output logic [CNT_W-1:0] sh_hper,
    output logic [CNT_W-1:0] sh_hwid,
    output logic [CNT_W-1:0] sh_hdly,
    output logic [IDX_W-1:0] run_idx
);

    logic [CNT_W-1:0] vcnt_q;
    logic [CNT_W-1:0] sh_vper_q;
    logic [CNT_W-1:0] sh_vwid_q;
    logic [CNT_W-1:0] vlen;
    logic [CNT_W-1:0] vlast;

    // a zero period behaves as a one-cycle frame
    assign vlen        = (sh_vper_q == '0) ? CNT_W'(1) : sh_vper_q;
    assign vlast       = vlen - CNT_W'(1);
    assign frame_start = (vcnt_q >= vlast);
    assign vact        = (vcnt_q < sh_vwid_q);

    // frame counter and shadow copy, reloaded only on the last cycle of a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q    <= '0;
            sh_vper_q <= '0;
            sh_vwid_q <= '0;
            sh_hper   <= '0;
            sh_hwid   <= '0;
            sh_hdly   <= '0;
            run_idx   <= '0;
        end else if (frame_start) begin
            vcnt_q    <= '0;
            sh_vper_q <= nx_vper;
            sh_vwid_q <= nx_vwid;
            sh_hper   <= nx_hper;
            sh_hwid   <= nx_hwid;
            sh_hdly   <= nx_hdly;
            run_idx   <= nx_idx;
        end else begin
            vcnt_q    <= vcnt_q + CNT_W'(1);
        end
    end

    // R1: the frame counter never passes the frame length
    p_vcnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vcnt_q < vlen);

    // R7: timing shadows hold for the whole frame
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable({sh_vper_q, sh_vwid_q, sh_hper, sh_hwid, sh_hdly}));

    // R8: the running set changes only at a frame start
    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(run_idx));

    // R2: a non-zero width makes the first frame cycle active
    p_vs_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (nx_vwid != '0)) |=> vact);

endmodule

// File: rtl/sns_sync_htimer.sv
module sns_sync_htimer
    import sns_sync_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] nx_hdly,
    input  logic [CNT_W-1:0] sh_hper,
    input  logic [CNT_W-1:0] sh_hwid,
    input  logic [CNT_W-1:0] sh_hdly,
    output logic             hact
);

    hs_state_e        state_q, state_d;
    logic [CNT_W-1:0] hcnt_q, hcnt_d;
    logic [CNT_W:0]   hcnt_inc;
    logic [CNT_W-1:0] hlen;
    logic             dly_done;
    logic             line_end;

    assign hcnt_inc = {1'b0, hcnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign hlen     = (sh_hper == '0) ? CNT_W'(1) : sh_hper;
    assign dly_done = (hcnt_inc >= {1'b0, sh_hdly});
    assign line_end = (hcnt_q >= (hlen - CNT_W'(1)));

    // next state and next count
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_inc[CNT_W-1:0];
        unique case (state_q)
            HS_WAIT: begin
                if (dly_done) begin
                    state_d = HS_RUN;
                    hcnt_d  = '0;
                end
            end
            HS_RUN: begin
                if (line_end) begin
                    hcnt_d = '0;
                end
            end
            default: begin
                state_d = HS_RUN;
                hcnt_d  = '0;
            end
        endcase
        if (frame_start) begin
            state_d = (nx_hdly == '0) ? HS_RUN : HS_WAIT;
            hcnt_d  = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    // outputs
    always_comb begin
        hact = 1'b0;
        unique case (state_q)
            HS_WAIT: hact = 1'b0;
            HS_RUN:  hact = (hcnt_q < sh_hwid);
            default: hact = 1'b0;
        endcase
    end

    // R3: the line counter restarts with each frame
    p_line_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (hcnt_q == '0));

    // R3: a frame with a non-zero delay opens in the waiting state
    p_wait_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (nx_hdly != '0)) |=> (state_q == HS_WAIT));

    // R4: inside a line the counter stays below the line length
    p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RUN) |-> (hcnt_q < hlen));

endmodule

// File: rtl/sns_sync_pin.sv
module sns_sync_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic en,
    input  logic inv,
    output logic pin_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_o <= 1'b0;
        end else begin
            pin_o <= (en & act) ^ inv;
        end
    end

    // R6: a disabled output sits at its idle level
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pin_o == $past(inv)));

    // R5: an enabled active phase drives the level opposite to the invert bit
    p_active_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act) |=> (pin_o != $past(inv)));

endmodule

// File: rtl/slave_sync_gen.sv
module slave_sync_gen
    import sns_sync_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_SET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              vsync_o,
    output logic              hsync_o
);

    localparam int unsigned IDX_W = (N_SET > 1) ? $clog2(N_SET) : 1;
    localparam int unsigned N_PIN = 2;

    pin_cfg_t         run_cfg;
    logic [IDX_W-1:0] sel, run_idx;
    logic [CNT_W-1:0] nx_vper, nx_hper, nx_vwid, nx_hwid, nx_hdly;
    logic [CNT_W-1:0] sh_hper, sh_hwid, sh_hdly;
    logic             frame_start, vact, hact;

    logic [N_PIN-1:0] p_act, p_en, p_inv, p_out;

    sns_sync_regs #(
        .CNT_W(CNT_W),
        .N_SET(N_SET),
        .IDX_W(IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_idx (run_idx),
        .run_cfg (run_cfg),
        .sel_o   (sel),
        .nx_vper (nx_vper),
        .nx_hper (nx_hper),
        .nx_vwid (nx_vwid),
        .nx_hwid (nx_hwid),
        .nx_hdly (nx_hdly)
    );

    sns_sync_vtimer #(
        .CNT_W(CNT_W),
        .IDX_W(IDX_W)
    ) u_vt (
        .clk         (clk),
        .rst_n       (rst_n),
        .nx_vper     (nx_vper),
        .nx_vwid     (nx_vwid),
        .nx_hper     (nx_hper),
        .nx_hwid     (nx_hwid),
        .nx_hdly     (nx_hdly),
        .nx_idx      (sel),
        .frame_start (frame_start),
        .vact        (vact),
        .sh_hper     (sh_hper),
        .sh_hwid     (sh_hwid),
        .sh_hdly     (sh_hdly),
        .run_idx     (run_idx)
    );

    sns_sync_htimer #(
        .CNT_W(CNT_W)
    ) u_ht (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .nx_hdly     (nx_hdly),
        .sh_hper     (sh_hper),
        .sh_hwid     (sh_hwid),
        .sh_hdly     (sh_hdly),
        .hact        (hact)
    );

    // channel 0 = vertical, channel 1 = horizontal
    assign p_act = {hact, vact};
    assign p_en  = {run_cfg.h_en, run_cfg.v_en};
    assign p_inv = {run_cfg.h_inv, run_cfg.v_inv};

    for (genvar c = 0; c < N_PIN; c++) begin : g_pin
        sns_sync_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (p_act[c]),
            .en    (p_en[c]),
            .inv   (p_inv[c]),
            .pin_o (p_out[c])
        );
    end

    assign vsync_o = p_out[0];
    assign hsync_o = p_out[1];

endmodule

// File: tb/sim_slave_sync_gen.sv
module sim_slave_sync_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        vsync, hsync;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_sync_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .vsync_o (vsync),
        .hsync_o (hsync)
    );

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        return (which == 0) ? vsync : hsync;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // counts falling-edge samples until the signal reaches lvl
    task automatic wait_lvl(input int which, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((sig(which) !== lvl) && (n < LIMIT));
        if (n >= LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL timeout: actual=%0d expected=<%0d", n, LIMIT);
        end
    endtask

    task automatic align_v(input logic act_lvl);
        int n;
        wait_lvl(0, !act_lvl, n);
        wait_lvl(0, act_lvl, n);
    endtask

    task automatic count_high(input int which, input int len, output int n);
        n = 0;
        repeat (len) begin
            @(negedge clk);
            if (sig(which)) n++;
        end
    endtask

    task automatic set0_basic;
        wr(3'd0, 32'hC000_0000);
        wr(3'd1, 32'd40);
        wr(3'd2, 32'd8);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd2);
        wr(3'd5, 32'd5);
    endtask

    task automatic t_reset;
        int n;
        chk("R9 vsync in reset", int'(vsync), 0);
        chk("R9 hsync in reset", int'(hsync), 0);
        rst_n = 1'b1;
        count_high(0, 20, n);
        chk("R9 vsync idle after reset", n, 0);
        count_high(1, 20, n);
        chk("R9 hsync idle after reset", n, 0);
    endtask

    task automatic t_reserved;
        int n;
        wr(3'd0, 32'h3FFC_FFFF);   // only reserved pin bits set (R10)
        count_high(0, 40, n);
        chk("R10 reserved bits leave vsync idle", n, 0);
        count_high(1, 40, n);
        chk("R10 reserved bits leave hsync idle", n, 0);
    endtask

    task automatic t_basic;
        int a, b, prev, rises;
        set0_basic();
        align_v(1);
        align_v(1);
        wait_lvl(1, 1, a);
        chk("R3 hsync delay after vsync", a, 5);
        wait_lvl(1, 0, a);
        chk("R4 hsync width", a, 2);
        wait_lvl(1, 1, b);
        chk("R3 hsync line period", a + b, 8);
        align_v(1);
        wait_lvl(0, 0, a);
        chk("R2 vsync width", a, 3);
        wait_lvl(0, 1, b);
        chk("R1 frame period", a + b, 40);
        rises = 0;
        prev  = int'(hsync);
        repeat (40) begin
            @(negedge clk);
            if (hsync && (prev == 0)) rises++;
            prev = int'(hsync);
        end
        chk("R3 hsync pulses per frame", rises, 5);
    endtask

    task automatic t_extremes;
        int n;
        wr(3'd4, 32'd0);
        align_v(1);
        align_v(1);
        count_high(1, 40, n);
        chk("R4 zero width suppresses hsync", n, 0);
        wr(3'd4, 32'd8);
        align_v(1);
        align_v(1);
        count_high(1, 39, n);
        chk("R4 full width holds hsync to frame end", n, 35);
        wr(3'd3, 32'd50);
        repeat (100) @(negedge clk);
        count_high(0, 80, n);
        chk("R2 width over period holds vsync", n, 80);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd2);
        align_v(1);
    endtask

    task automatic t_polarity;
        int a;
        wr(3'd0, 32'hC003_0000);
        align_v(0);
        align_v(0);
        wait_lvl(1, 0, a);
        chk("R5 inverted hsync delay", a, 5);
        align_v(0);
        wait_lvl(0, 1, a);
        chk("R5 inverted vsync low width", a, 3);
        align_v(0);
        wr(3'd0, 32'hC000_0000);   // back to active high at frame offset 0
        @(negedge clk);
        chk("R5 polarity applied without frame wait", int'(vsync), 1);
        chk("R5 hsync idle level after polarity change", int'(hsync), 0);
    endtask

    task automatic t_enable;
        int n;
        wr(3'd0, 32'h0003_0000);
        repeat (2) @(negedge clk);
        count_high(0, 80, n);
        chk("R6 disabled vsync held at inverted idle", n, 80);
        count_high(1, 80, n);
        chk("R6 disabled hsync held at inverted idle", n, 80);
        wr(3'd0, 32'h0000_0000);
        repeat (2) @(negedge clk);
        count_high(0, 80, n);
        chk("R6 disabled vsync held low", n, 0);
        wr(3'd0, 32'hC000_0000);
    endtask

    task automatic t_deferred;
        int a, b;
        align_v(1);
        align_v(1);
        repeat (10) @(negedge clk);
        wr(3'd1, 32'd60);          // presented at frame offset 10
        wait_lvl(0, 1, a);
        chk("R7 current frame keeps old period", 11 + a, 40);
        wait_lvl(0, 0, a);
        wait_lvl(0, 1, b);
        chk("R7 next frame uses new period", a + b, 60);
    endtask

    task automatic t_select;
        int a, b;
        wr(3'd6, 32'd1);
        wr(3'd0, 32'hC000_0000);
        wr(3'd1, 32'd24);
        wr(3'd2, 32'd6);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd3);
        align_v(1);
        align_v(1);
        wait_lvl(0, 0, a);
        wait_lvl(0, 1, b);
        chk("R8 set 1 vsync width", a, 2);
        chk("R8 set 1 frame period", a + b, 24);
        wait_lvl(1, 1, a);
        chk("R8 set 1 hsync delay", a, 3);
        wr(3'd6, 32'd0);
        align_v(1);
        align_v(1);
        wait_lvl(0, 0, a);
        wait_lvl(0, 1, b);
        chk("R8 set 0 width kept", a, 3);
        chk("R8 set 0 period kept", a + b, 60);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_reserved();
        t_basic();
        t_extremes();
        t_polarity();
        t_enable();
        t_deferred();
        t_select();
        finish_run();
    end

endmodule